// File: doc/BRIEF.md
# Line-Fragmenting Scratchpad Copy Engine

This block copies a byte range from one place in an on-chip scratchpad to another. It accepts a single command made of a source byte address, a destination byte address, a byte length and a programmable startup delay. The command is split into one write transaction for each 128-byte destination line that the range covers. The block talks to a dual-port scratchpad through a line-wide synchronous read port and a line-wide write port with per-byte enables.

The block compares the source and destination offsets inside a line. If they are equal, each destination line is one source line passed straight through, and a new line is written every cycle. If they differ, a holding register keeps the previous source line. Each destination line is then built by shifting bytes across the held line and the newly read line, and every line pays a fixed realignment penalty. A fixed startup delay comes before the first line of every command. The `busy` output covers the whole transfer, and `done` pulses once at the end.

Top module: `line_copier`

## Requirements
- R1: When `start` is high while `busy` is low, the command inputs are captured and `busy` is high from the next cycle on.
- R2: A command of length L at destination address D makes exactly one write for each line it touches. That is ((D mod 128) + L - 1) / 128 + 1 writes, made in ascending line order starting at line D / 128.
- R3: The first and last lines of a transfer are written with byte enables that cover only the requested bytes. Lines in between have all 128 enables set. No byte outside the destination range changes.
- R4: When (source - destination) mod 128 is 0, every destination byte receives the matching source byte, and each line costs one cycle.
- R5: When (source - destination) mod 128 is not 0, every destination byte still receives the matching source byte, and each line costs 1 + PENALTY cycles (default PENALTY = 16, PENALTY must be at least 1).
- R6: `done` goes high exactly S + N × (per-line cycles) clock edges after the edge that accepted the command. N is the line count from R2. S is `cfg_delay`, where a value of 0 behaves as 1.
- R7: A zero-length command raises `done` after S cycles and makes no write.
- R8: A `start` that arrives while `busy` is high is ignored. The running transfer, its timing and the scratchpad contents are unchanged.
- R9: `done` lasts exactly one cycle, and `busy` is low whenever `done` is high.
- R10: While in reset and right after it, `busy`, `done`, `rd_en` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command strobe |
| src_addr | input | 12 | Source byte address |
| dst_addr | input | 12 | Destination byte address |
| len | input | 13 | Byte count (0 to 4096) |
| cfg_delay | input | DLY_W | Startup delay in cycles (0 behaves as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Scratchpad line read request |
| rd_line | output | 5 | Line index to read |
| rd_data | input | 1024 | Read line, valid the cycle after `rd_en` |
| wr_en | output | 1 | Scratchpad line write |
| wr_line | output | 5 | Line index to write |
| wr_data | output | 1024 | Write line data |
| wr_be | output | 128 | Per-byte write enables |

## Verification
The bench targets short ranges that start partway into a line, end partway into a line, or hold a single byte. An engine with wrong first-line or last-line enables would overwrite neighbouring bytes, and that shows up when the whole scratchpad is compared against a byte-level reference. The misaligned cases include a source offset smaller than the destination offset, so the first source line index wraps below zero. Getting the shift direction or the borrow wrong would copy bytes displaced by one line or by the offset difference. Exact done timing is checked for both paths, for a zero delay, for a zero length, and for a second `start` sent mid-transfer. A design that re-armed on that second strobe would end late and write into the intruder's destination.

// File: rtl/line_copier_pkg.sv
package line_copier_pkg;

    localparam int LINE_BYTES = 128;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int ADDR_W     = 12;
    localparam int LN_W       = ADDR_W - OFF_W;
    localparam int LEN_W      = ADDR_W + 1;
    localparam int CNT_W      = LEN_W - OFF_W + 1;

    typedef logic [LINE_W-1:0]     line_t;
    typedef logic [LINE_BYTES-1:0] be_t;
    typedef logic [OFF_W-1:0]      off_t;
    typedef logic [LN_W-1:0]       ln_t;
    typedef logic [CNT_W-1:0]      lcnt_t;

    typedef enum logic [1:0] {
        CP_IDLE,
        CP_WAIT,
        CP_LINE
    } cp_state_e;

    typedef struct packed {
        ln_t   dst_ln;
        ln_t   src_ln;
        off_t  head;
        off_t  tail;
        off_t  shift;
        logic  misal;
        lcnt_t nlines;
    } xfer_geom_t;

    function automatic be_t edge_mask(off_t head, off_t tail, logic first, logic last);
        be_t m;
        for (int i = 0; i < LINE_BYTES; i++) begin
            m[i] = (!first || (OFF_W'(i) >= head)) && (!last || (OFF_W'(i) <= tail));
        end
        return m;
    endfunction

    function automatic line_t realign(line_t lo, line_t hi, off_t sh);
        logic [2*LINE_W-1:0] cat;
        cat = {hi, lo} >> {sh, 3'b000};
        return cat[LINE_W-1:0];
    endfunction

endpackage

// File: rtl/lcopy_geom.sv
module lcopy_geom
    import line_copier_pkg::*;
(
    input  logic [ADDR_W-1:0] src,
    input  logic [ADDR_W-1:0] dst,
    input  logic [LEN_W-1:0]  len,
    output xfer_geom_t        geom
);
    off_t             soff;
    off_t             head;
    logic [LEN_W:0]   span;

    always_comb begin
        soff = src[OFF_W-1:0];
        head = dst[OFF_W-1:0];
        span = {{(LEN_W+1-OFF_W){1'b0}}, head} + {1'b0, len} - {{LEN_W{1'b0}}, 1'b1};

        geom.dst_ln = dst[ADDR_W-1:OFF_W];
        geom.src_ln = src[ADDR_W-1:OFF_W] - ln_t'(soff < head);
        geom.head   = head;
        geom.tail   = span[OFF_W-1:0];
        geom.shift  = soff - head;
        geom.misal  = (soff != head);
        geom.nlines = (len == '0) ? '0 : (span[LEN_W:OFF_W] + lcnt_t'(1));
    end
endmodule

// File: rtl/lcopy_realign.sv
module lcopy_realign
    import line_copier_pkg::*;
(
    input  line_t lo_line,
    input  line_t hi_line,
    input  off_t  shift,
    input  off_t  head,
    input  off_t  tail,
    input  logic  first,
    input  logic  last,
    output line_t data,
    output be_t   be
);
    always_comb begin
        data = realign(lo_line, hi_line, shift);
        be   = edge_mask(head, tail, first, last);
    end
endmodule

// File: rtl/line_copier.sv
module line_copier
    import line_copier_pkg::*;
#(
    parameter int PENALTY = 16,
    parameter int DLY_W   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [LEN_W-1:0]  len,
    input  logic [DLY_W-1:0]  cfg_delay,
    output logic              busy,
    output logic              done,
    output logic              rd_en,
    output logic [LN_W-1:0]   rd_line,
    input  logic [LINE_W-1:0] rd_data,
    output logic              wr_en,
    output logic [LN_W-1:0]   wr_line,
    output logic [LINE_W-1:0] wr_data,
    output logic [LINE_BYTES-1:0] wr_be
);
    localparam int PH_W = $clog2(PENALTY + 1);

    cp_state_e        state;
    xfer_geom_t       geom_in;
    logic [DLY_W-1:0] cnt;
    logic [PH_W-1:0]  phase;
    lcnt_t            left;
    lcnt_t            nlines_q;
    ln_t              src_ln, dst_ln;
    off_t             shift_q, head_q, tail_q;
    logic             misal_q, first_q, done_q;
    line_t            hold;
    line_t            lo_sel;
    logic             last_line, step_end;

    lcopy_geom u_geom (
        .src  (src_addr),
        .dst  (dst_addr),
        .len  (len),
        .geom (geom_in)
    );

    assign last_line = (left == lcnt_t'(1));
    assign step_end  = misal_q ? (phase == PH_W'(PENALTY)) : 1'b1;
    assign lo_sel    = misal_q ? hold : rd_data;

    lcopy_realign u_align (
        .lo_line (lo_sel),
        .hi_line (rd_data),
        .shift   (shift_q),
        .head    (head_q),
        .tail    (tail_q),
        .first   (first_q),
        .last    (last_line),
        .data    (wr_data),
        .be      (wr_be)
    );

    always_comb begin
        rd_en = 1'b0;
        if (state == CP_WAIT)
            rd_en = (cnt == DLY_W'(1)) && (nlines_q != '0);
        else if (state == CP_LINE)
            rd_en = misal_q ? (phase == '0) : !last_line;
    end

    assign rd_line = src_ln;
    assign wr_en   = (state == CP_LINE) && step_end;
    assign wr_line = dst_ln;
    assign busy    = (state != CP_IDLE);
    assign done    = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= CP_IDLE;
            done_q   <= 1'b0;
            cnt      <= '0;
            phase    <= '0;
            left     <= '0;
            nlines_q <= '0;
            src_ln   <= '0;
            dst_ln   <= '0;
            shift_q  <= '0;
            head_q   <= '0;
            tail_q   <= '0;
            misal_q  <= 1'b0;
            first_q  <= 1'b0;
            hold     <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                CP_IDLE: begin
                    if (start) begin
                        src_ln   <= geom_in.src_ln;
                        dst_ln   <= geom_in.dst_ln;
                        head_q   <= geom_in.head;
                        tail_q   <= geom_in.tail;
                        shift_q  <= geom_in.shift;
                        misal_q  <= geom_in.misal;
                        nlines_q <= geom_in.nlines;
                        left     <= geom_in.nlines;
                        first_q  <= 1'b1;
                        phase    <= '0;
                        cnt      <= (cfg_delay == '0) ? DLY_W'(1) : cfg_delay;
                        state    <= CP_WAIT;
                    end
                end
                CP_WAIT: begin
                    if (cnt == DLY_W'(1)) begin
                        if (nlines_q == '0) begin
                            done_q <= 1'b1;
                            state  <= CP_IDLE;
                        end else begin
                            src_ln <= src_ln + ln_t'(1);
                            state  <= CP_LINE;
                        end
                    end else begin
                        cnt <= cnt - DLY_W'(1);
                    end
                end
                CP_LINE: begin
                    if (misal_q) begin
                        if (phase == '0) begin
                            hold   <= rd_data;
                            src_ln <= src_ln + ln_t'(1);
                        end
                    end else if (!last_line) begin
                        src_ln <= src_ln + ln_t'(1);
                    end
                    if (step_end) begin
                        phase   <= '0;
                        first_q <= 1'b0;
                        dst_ln  <= dst_ln + ln_t'(1);
                        left    <= left - lcnt_t'(1);
                        if (last_line) begin
                            done_q <= 1'b1;
                            state  <= CP_IDLE;
                        end
                    end else begin
                        phase <= phase + PH_W'(1);
                    end
                end
                default: state <= CP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/line_copier_chk.sv
module line_copier_chk
    import line_copier_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      start,
    input logic      busy,
    input logic      done,
    input logic      wr_en,
    input logic      rd_en,
    input logic [LINE_BYTES-1:0] wr_be
);
    // R1
    accept_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R2
    write_in_transfer_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy);

    // R3
    enables_present_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_be != '0));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10
    quiet_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!wr_en && !rd_en));
endmodule

bind line_copier line_copier_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .busy  (busy),
    .done  (done),
    .wr_en (wr_en),
    .rd_en (rd_en),
    .wr_be (wr_be)
);

// File: tb/sim_line_copier.sv
`timescale 1ns/1ps
module sim_line_copier;
    import line_copier_pkg::*;

    localparam int PEN       = 16;
    localparam int DW        = 10;
    localparam int MEM_BYTES = 1 << ADDR_W;
    localparam int NVEC      = 8;
    // src, dst, len, delay
    localparam int VEC [0:NVEC-1][0:3] = '{
        '{0,    1024,  128, 5},
        '{256,  1536,  300, 3},
        '{10,   2058,  200, 4},
        '{5,    2118,  250, 2},
        '{130,  3000,    1, 1},
        '{300,  3200,  513, 7},
        '{127,  2560,    2, 2},
        '{700,  1100,    0, 6}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [ADDR_W-1:0] src_addr = '0;
    logic [ADDR_W-1:0] dst_addr = '0;
    logic [LEN_W-1:0]  len = '0;
    logic [DW-1:0]     cfg_delay = '0;
    logic              busy, done, rd_en, wr_en;
    logic [LN_W-1:0]   rd_line, wr_line;
    logic [LINE_W-1:0] rd_data = '0;
    logic [LINE_W-1:0] wr_data;
    logic [LINE_BYTES-1:0] wr_be;

    logic [7:0] mem   [0:MEM_BYTES-1];
    logic [7:0] ref_m [0:MEM_BYTES-1];
    int wcnt = 0;
    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    line_copier #(.PENALTY(PEN), .DLY_W(DW)) u0 (
        .clk(clk), .rst(rst), .start(start), .src_addr(src_addr), .dst_addr(dst_addr),
        .len(len), .cfg_delay(cfg_delay), .busy(busy), .done(done), .rd_en(rd_en),
        .rd_line(rd_line), .rd_data(rd_data), .wr_en(wr_en), .wr_line(wr_line),
        .wr_data(wr_data), .wr_be(wr_be)
    );

    always @(posedge clk) begin
        if (rd_en)
            for (int b = 0; b < LINE_BYTES; b++)
                rd_data[b*8 +: 8] <= mem[int'(rd_line) * LINE_BYTES + b];
        if (wr_en) begin
            wcnt <= wcnt + 1;
            for (int b = 0; b < LINE_BYTES; b++)
                if (wr_be[b]) mem[int'(wr_line) * LINE_BYTES + b] <= wr_data[b*8 +: 8];
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int s, input int d, input int l, input int dl,
                            input bit intr, input string tg);
        int n, t, cyc, bad, bad_at, bad_act, bad_exp;
        bit mis;
        for (int i = 0; i < MEM_BYTES; i++) begin
            mem[i]   = 8'(i * 37 + s + d * 3 + 5);
            ref_m[i] = mem[i];
        end
        for (int i = 0; i < l; i++) ref_m[d + i] = mem[s + i];
        n   = (l == 0) ? 0 : (((d % LINE_BYTES) + l - 1) / LINE_BYTES + 1);
        mis = ((s - d) % LINE_BYTES) != 0;
        t   = ((dl == 0) ? 1 : dl) + n * (mis ? 1 + PEN : 1);
        wcnt = 0;
        src_addr = ADDR_W'(s); dst_addr = ADDR_W'(d); len = LEN_W'(l);
        cfg_delay = DW'(dl); start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0; cyc = 0;
        chk(busy == 1'b1, "R1", {tg, " busy after accept"}, int'(busy), 1);
        while (!done && cyc < 20000) begin
            if (intr && cyc == 1) begin
                start = 1'b1; src_addr = 12'd2000; dst_addr = 12'd3500; len = 13'd50;
            end else begin
                start = 1'b0;
            end
            @(posedge clk); @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        chk(cyc == t, mis ? "R5/R6" : "R4/R6", {tg, " cycles to done"}, cyc, t);
        chk(wcnt == n, l == 0 ? "R7" : "R2", {tg, " line writes"}, wcnt, n);
        chk(busy == 1'b0, "R9", {tg, " busy low with done"}, int'(busy), 0);
        @(posedge clk); @(negedge clk);
        chk(done == 1'b0, "R9", {tg, " done width"}, int'(done), 0);
        bad = 0; bad_at = 0; bad_act = 0; bad_exp = 0;
        for (int i = 0; i < MEM_BYTES; i++)
            if (mem[i] !== ref_m[i]) begin
                if (bad == 0) begin bad_at = i; bad_act = int'(mem[i]); bad_exp = int'(ref_m[i]); end
                bad++;
            end
        chk(bad == 0, intr ? "R8" : (mis ? "R3/R5" : "R3/R4"),
            $sformatf("%s bytes at %0d", tg, bad_at), bad_act, bad_exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0, "R10",
            "outputs in reset", int'({busy, done, wr_en, rd_en}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && wr_en == 1'b0 && rd_en == 1'b0, "R10",
            "outputs after reset", int'({busy, done, wr_en, rd_en}), 0);
        for (int v = 0; v < NVEC; v++)
            run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], 1'b0,
                     $sformatf("vec%0d", v));
        // R6 zero delay behaves as one
        run_case(0, 512, 64, 0, 1'b0, "R6 zero delay");
        // R7 zero length with zero delay
        run_case(40, 900, 0, 0, 1'b0, "R7 empty");
        // R8 second start while busy
        run_case(0, 1024, 256, 3, 1'b1, "R8 intruder");
        // R5 full misaligned span with wrap of first source line
        run_case(3, 2200, 600, 2, 1'b0, "R5 wrap");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule